// File: doc/BRIEF.md
# Transmit Clock Activity Monitor

This block watches the transmit clock of every channel of a multi-channel line transmitter and decides, per channel, whether the transmitter runs normally, sends a continuous all-ones signal, or is powered down with its driver tri-stated. Each channel clock is compared against a reference clock. The reference is a free-running master clock while that clock toggles. When the master clock is stuck, the transmit clock of one designated channel becomes the reference.

All clocks are brought into a fast sampling clock domain through a two-flop synchronizer, and all decisions are made there. A channel whose clock holds high for more than a set number of reference ticks switches to all-ones. The all-ones output is a strobe that marks each reference tick. A channel whose clock holds low for a longer set number of ticks is powered down. If neither the master clock nor the backup channel clock toggles, every channel is powered down. The first edge seen on a channel clock returns that channel to normal.

Top module: `txclk_watch`

## Requirements
- R1: While reset is high, and after reset until a channel clock edge is seen, each channel's 2-bit mode field reads 2'b10 (power-down), its driver enable is 0 and its all-ones strobe is 0. Channel i's mode sits at mode_o[2i+1:2i].
- R2: When the selected reference and a channel clock both toggle, that channel's mode is 2'b00 (normal) and its driver enable is 1.
- R3: A channel clock held high for more than HI_LIMIT reference ticks (rising edges of the reference) gives mode 2'b01 (all ones), driver enable 1. It is still 2'b00 after fewer than HI_LIMIT ticks.
- R4: A channel clock held low for LO_LIMIT reference ticks gives mode 2'b10 with driver enable 0. It is still 2'b00 after fewer ticks.
- R5: The master clock is declared absent after ABSENT_CYC sampling cycles without a master edge and present again at its next edge. While it is absent, rising edges of channel REF_IDX's clock are the reference ticks.
- R6: After all-ones or power-down, a synchronized edge on the channel clock returns the mode to 2'b00 on the next sampling cycle.
- R7: When both the master clock and the clock of channel REF_IDX are absent, every channel reads 2'b10 with driver enable 0.
- R8: In all-ones mode, ones_stb_o pulses for one sampling cycle per reference tick. Outside that mode, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than all monitored clocks |
| rst | input | 1 | Synchronous active-high reset |
| mclk_i | input | 1 | Free-running master clock (asynchronous) |
| tclk_i | input | NCH | Channel transmit clocks (asynchronous) |
| mode_o | output | 2*NCH | Per-channel mode: 00 normal, 01 all ones, 10 power-down |
| drv_en_o | output | NCH | Per-channel line driver enable (0 = tri-state) |
| ones_stb_o | output | NCH | Per-channel all-ones bit strobe, one pulse per reference tick |

## Verification
The assertions check four relations on every cycle:
- A synchronized channel edge leads to normal mode on the next cycle.
- A missing reference leads to power-down.
- Entry into all-ones happens only with the clock level high.
- Strobes appear only in all-ones mode, and the presence flags follow edges.

The tick counts at which all-ones and power-down begin, the switch to the backup channel after the master clock stops, and the number of strobes per interval can only be shown by the bench's scenarios.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic [1:0] {
    TXM_RUN  = 2'b00,
    TXM_ONES = 2'b01,
    TXM_OFF  = 2'b10
  } txm_e;
endpackage

// File: rtl/txw_sync.sv
module txw_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/txw_presence.sv
module txw_presence #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic present_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] idle_q;
  logic          present_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q    <= '0;
      present_q <= 1'b0;
    end else if (edge_i) begin
      idle_q    <= '0;
      present_q <= 1'b1;
    end else begin
      if (idle_q != CW'(LIMIT)) idle_q <= idle_q + 1'b1;
      if (idle_q == CW'(LIMIT - 1)) present_q <= 1'b0;
    end
  end

  assign present_o = present_q;

  // R5: an edge always makes the clock present on the next cycle
  a_r5_edge_present: assert property (@(posedge clk) disable iff (rst)
    edge_i |=> present_q);
  // R5: presence is only lost in a cycle without an edge
  a_r5_loss_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(present_q) |-> !$past(edge_i));
endmodule

// File: rtl/txw_chan.sv
module txw_chan
  import txw_pkg::*;
#(
  parameter int HI_LIMIT = 16,
  parameter int LO_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic tog_i,
  input  logic tick_i,
  input  logic ref_ok_i,
  output txm_e mode_o,
  output logic drv_en_o,
  output logic ones_stb_o
);
  localparam int CW = $clog2(LO_LIMIT + 1);

  txm_e          mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          drv_q, stb_q;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (!ref_ok_i) begin
      mode_d = TXM_OFF;
      cnt_d  = '0;
    end else if (tog_i) begin
      mode_d = TXM_RUN;
      cnt_d  = '0;
    end else if (tick_i) begin
      if (cnt_q != CW'(LO_LIMIT)) cnt_d = cnt_q + 1'b1;
      if (lvl_i && cnt_d > CW'(HI_LIMIT)) mode_d = TXM_ONES;
      if (!lvl_i && cnt_d >= CW'(LO_LIMIT)) mode_d = TXM_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TXM_OFF;
      cnt_q  <= '0;
      drv_q  <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      drv_q  <= (mode_d != TXM_OFF);
      stb_q  <= (mode_d == TXM_ONES) && tick_i && ref_ok_i;
    end
  end

  assign mode_o     = mode_q;
  assign drv_en_o   = drv_q;
  assign ones_stb_o = stb_q;

  // R6: any synchronized edge with a live reference restores normal mode
  a_r6_edge_run: assert property (@(posedge clk) disable iff (rst)
    (ref_ok_i && tog_i) |=> mode_q == TXM_RUN);
  // R7: no reference at all forces power-down
  a_r7_noref_off: assert property (@(posedge clk) disable iff (rst)
    !ref_ok_i |=> mode_q == TXM_OFF);
  // R3: all-ones is entered only from a high clock level
  a_r3_ones_high: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TXM_ONES && $past(mode_q) != TXM_ONES) |-> $past(lvl_i));
  // R8: strobes only in all-ones mode
  a_r8_stb_ones: assert property (@(posedge clk) disable iff (rst)
    ones_stb_o |-> mode_q == TXM_ONES);
  // R4: the driver is off whenever the channel is powered down
  a_r4_off_drv: assert property (@(posedge clk) disable iff (rst)
    mode_q == TXM_OFF |-> !drv_en_o);
endmodule

// File: rtl/txclk_watch.sv
module txclk_watch
  import txw_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int HI_LIMIT   = 16,
  parameter int LO_LIMIT   = 64,
  parameter int ABSENT_CYC = 32,
  parameter int REF_IDX    = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mclk_i,
  input  logic [NCH-1:0]   tclk_i,
  output logic [2*NCH-1:0] mode_o,
  output logic [NCH-1:0]   drv_en_o,
  output logic [NCH-1:0]   ones_stb_o
);
  localparam int SW = NCH + 1;

  logic [SW-1:0] s_lvl, s_prev, s_tog;
  logic          m_rise, b_rise, m_pres, b_pres, ref_ok, tick;

  txw_sync #(.W(SW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({mclk_i, tclk_i}),
    .q_o (s_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) s_prev <= '0;
    else     s_prev <= s_lvl;
  end

  assign s_tog  = s_lvl ^ s_prev;
  assign m_rise = s_lvl[NCH] & ~s_prev[NCH];
  assign b_rise = s_lvl[REF_IDX] & ~s_prev[REF_IDX];

  txw_presence #(.LIMIT(ABSENT_CYC)) u_mpres (
    .clk       (clk),
    .rst       (rst),
    .edge_i    (s_tog[NCH]),
    .present_o (m_pres)
  );

  txw_presence #(.LIMIT(ABSENT_CYC)) u_bpres (
    .clk       (clk),
    .rst       (rst),
    .edge_i    (s_tog[REF_IDX]),
    .present_o (b_pres)
  );

  assign ref_ok = m_pres | b_pres;
  assign tick   = m_pres ? m_rise : b_rise;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    txm_e mode_w;
    txw_chan #(.HI_LIMIT(HI_LIMIT), .LO_LIMIT(LO_LIMIT)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .lvl_i      (s_lvl[i]),
      .tog_i      (s_tog[i]),
      .tick_i     (tick),
      .ref_ok_i   (ref_ok),
      .mode_o     (mode_w),
      .drv_en_o   (drv_en_o[i]),
      .ones_stb_o (ones_stb_o[i])
    );
    assign mode_o[2*i +: 2] = mode_w;
  end
endmodule

// File: tb/txclk_watch_bench.sv
module txclk_watch_bench;
  localparam int PERIOD = 10;
  localparam int NCH    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mrun = 1'b1;
  logic [7:0]       ctl = 8'h00;  // per channel: 0 toggle, 1 stuck high, 2 stuck low
  logic             mdiv = 1'b0, tdiv = 1'b0;
  int               mcnt = 0, tcnt = 0;
  logic             mclk;
  logic [NCH-1:0]   tclk;
  logic [2*NCH-1:0] mode;
  logic [NCH-1:0]   drv_en, ones_stb;
  int               total = 0, bad = 0;
  bit               done = 0;

  always #(PERIOD/2) clk = ~clk;

  // master toggles every 2 sampling cycles, channel clocks every 3
  always @(posedge clk) begin
    mcnt <= (mcnt == 1) ? 0 : mcnt + 1;
    if (mcnt == 1) mdiv <= ~mdiv;
    tcnt <= (tcnt == 2) ? 0 : tcnt + 1;
    if (tcnt == 2) tdiv <= ~tdiv;
  end

  assign mclk = mrun ? mdiv : 1'b0;
  always_comb
    for (int i = 0; i < NCH; i++)
      tclk[i] = (ctl[2*i +: 2] == 2'd0) ? tdiv : (ctl[2*i +: 2] == 2'd1);

  txclk_watch u_txclk_watch (
    .clk        (clk),
    .rst        (rst),
    .mclk_i     (mclk),
    .tclk_i     (tclk),
    .mode_o     (mode),
    .drv_en_o   (drv_en),
    .ones_stb_o (ones_stb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] oe_of(input logic [7:0] m);
    logic [3:0] r;
    for (int i = 0; i < NCH; i++) r[i] = (m[2*i +: 2] != 2'b10);
    return r;
  endfunction

  // {mrun, ctl[7:0], wait cycles[11:0], expected modes[7:0]}
  localparam logic [28:0] VEC [0:8] = '{
    {1'b1, 8'h00, 12'd40,  8'h00},  // R2 all toggling
    {1'b1, 8'h04, 12'd52,  8'h00},  // R3 ch1 high, under limit
    {1'b1, 8'h04, 12'd40,  8'h04},  // R3 ch1 high past limit
    {1'b1, 8'h24, 12'd200, 8'h04},  // R4 ch2 low, under limit
    {1'b1, 8'h24, 12'd100, 8'h24},  // R4 ch2 low past limit
    {1'b1, 8'h00, 12'd20,  8'h00},  // R6 recovery
    {1'b0, 8'h40, 12'd200, 8'h40},  // R5 master gone, backup times ch3
    {1'b0, 8'h02, 12'd60,  8'hAA},  // R7 backup gone too
    {1'b1, 8'h00, 12'd60,  8'h00}   // R6 recovery from all off
  };

  initial begin
    int n1, n0;
    repeat (4) @(negedge clk);
    chk("R1 mode", 32'(mode), 32'h00AA);
    chk("R1 drv_en", 32'(drv_en), 32'h0);
    chk("R1 ones_stb", 32'(ones_stb), 32'h0);
    rst = 1'b0;

    for (int k = 0; k < 9; k++) begin
      mrun = VEC[k][28];
      ctl  = VEC[k][27:20];
      repeat (int'(VEC[k][19:8])) @(negedge clk);
      chk($sformatf("R2-table step %0d mode", k), 32'(mode), 32'(VEC[k][7:0]));
      chk($sformatf("R4 table step %0d drv_en", k), 32'(drv_en), 32'(oe_of(VEC[k][7:0])));
    end

    // R8: strobe count while ch1 sends all ones (one tick per 4 cycles)
    ctl = 8'h04;
    repeat (120) @(negedge clk);
    n1 = 0; n0 = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (ones_stb[1]) n1++;
      if (ones_stb[0]) n0++;
    end
    chk("R8 strobes in all-ones", 32'((n1 >= 9 && n1 <= 11) ? 1 : 0), 32'd1);
    chk("R8 no strobes in normal", 32'(n0), 32'd0);

    // R6: edge returns ch1 to normal within a few sampling cycles
    ctl = 8'h00;
    repeat (8) @(negedge clk);
    chk("R6 edge restores normal", 32'(mode), 32'h0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule